// File: doc/BRIEF.md
# Four-Operation 8-bit Teaching Core

This block is a compact processor core for a four-operation instruction set meant for classroom use. It keeps four 8-bit general registers and an 8-bit program counter. Each cycle it reads one instruction byte through a byte-wide instruction port. The top two bits of the byte pick one of four operations: put a small constant into a register, add two registers, subtract one register from another, or write a register to data memory.

Every operation fits in a single byte except the memory write. That operation pulls a second byte from the instruction stream and uses it as the direct data-memory address, so the fetch sequence has variable length. The core has no pipeline. Every byte fetched costs one clock. The program counter therefore steps by one on every cycle out of reset, and a memory write occupies two cycles.

A debug port shows any register and the current program counter. A testbench can use it to follow architectural state after each instruction retires. The instruction port is read combinationally: the byte at `imem_addr` must be on `imem_rdata` in the same cycle.

Top module: `tiny8_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, the program counter and all four registers become zero and `dmem_we` becomes 0, even if a memory write was half fetched.
- R2: A byte with bits [7:6] = 00 writes bits [3:0], zero-extended, into the register that bits [5:4] select. It retires at the edge that fetches it.
- R3: A byte with bits [7:6] = 01 writes (register[bits 3:2] + register[bits 1:0]) mod 256 into register[bits 5:4].
- R4: A byte with bits [7:6] = 10 writes (register[bits 3:2] − register[bits 1:0]) mod 256 into register[bits 5:4].
- R5: A byte with bits [7:6] = 11 takes the next instruction byte as an address. After the edge that fetches that address byte, `dmem_we` is 1 for exactly one cycle, with `dmem_addr` equal to the address byte and `dmem_wdata` equal to the register that bits [5:4] of the first byte select.
- R6: A memory write changes no register, and bits [3:0] of its first byte have no effect.
- R7: Outside reset, the program counter increases by 1 at every edge. A one-byte instruction therefore advances it by 1 and a memory write by 2, and it wraps from 255 to 0. This includes a write whose opcode sits at 255 and whose address byte sits at 0.
- R8: `dmem_we` stays 0 after any one-byte instruction.
- R9: `dbg_rdata` shows, in the same cycle, the register chosen by `dbg_sel`. `dbg_pc` and `imem_addr` show the current program counter.
- R10: Register 0 behaves like any other register. A destination may also be one of the sources, in which case the result is computed from the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Instruction byte address (the program counter) |
| imem_rdata | input | 8 | Instruction byte at `imem_addr`, same cycle |
| dmem_we | output | 1 | Data-memory write enable, one-cycle pulse |
| dmem_addr | output | 8 | Data-memory write address |
| dmem_wdata | output | DATA_W | Data-memory write data |
| dbg_sel | input | 2 | Register chosen for the debug view |
| dbg_rdata | output | DATA_W | Value of the chosen register |
| dbg_pc | output | PC_W | Current program counter |

## Verification
The main program uses every operation with sources that produce both carry and borrow. That exposes a missing modulo-256 wrap, and swapped source fields in subtraction. The program also makes a destination equal to its own source, to separate old-value reads from new-value reads. It writes register 0 and reads it back, and it runs two memory writes back to back to check that the enable drops between them. One write carries junk in its low bits and an address of 255. A separate run places a memory write across the 255→0 counter wrap. Another asserts reset in the middle of a memory write, which shows whether reset takes priority over the pending memory write.

// File: rtl/tiny8_pkg.sv
package tiny8_pkg;

  localparam int INSTR_W   = 8;
  localparam int REG_SEL_W = 2;
  localparam int NREG      = 1 << REG_SEL_W;
  localparam int IMM_W     = 2 * REG_SEL_W;

  typedef enum logic [1:0] {
    OP_LDI = 2'b00,
    OP_ADD = 2'b01,
    OP_SUB = 2'b10,
    OP_STR = 2'b11
  } opc_e;

  typedef struct packed {
    opc_e                 op;
    logic [REG_SEL_W-1:0] rd;
    logic [REG_SEL_W-1:0] rs1;
    logic [REG_SEL_W-1:0] rs2;
  } instr_t;

  typedef enum logic {
    PH_EXEC = 1'b0,
    PH_ADDR = 1'b1
  } phase_e;

endpackage

// File: rtl/tiny8_pc.sv
module tiny8_pc #(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PC_W-1:0] pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(1);

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc + STEP;
  end
endmodule

// File: rtl/tiny8_regfile.sv
module tiny8_regfile
  import tiny8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [REG_SEL_W-1:0] wr_sel,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [REG_SEL_W-1:0] ra_sel,
  input  logic [REG_SEL_W-1:0] rb_sel,
  input  logic [REG_SEL_W-1:0] rc_sel,
  output logic [DATA_W-1:0]    ra_data,
  output logic [DATA_W-1:0]    rb_data,
  output logic [DATA_W-1:0]    rc_data
);
  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (wr_en && (wr_sel == REG_SEL_W'(g)))
        regs[g] <= wr_data;
    end
  end

  assign ra_data = regs[ra_sel];
  assign rb_data = regs[rb_sel];
  assign rc_data = regs[rc_sel];
endmodule

// File: rtl/tiny8_exec.sv
module tiny8_exec
  import tiny8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 active,
  input  instr_t               ins,
  input  logic [DATA_W-1:0]    src_a,
  input  logic [DATA_W-1:0]    src_b,
  output logic                 wr_en,
  output logic [REG_SEL_W-1:0] wr_sel,
  output logic [DATA_W-1:0]    wr_data,
  output logic                 starts_store
);
  logic [IMM_W-1:0] imm;

  assign imm    = {ins.rs1, ins.rs2};
  assign wr_sel = ins.rd;

  always_comb begin
    wr_en        = 1'b0;
    wr_data      = '0;
    starts_store = 1'b0;
    if (active) begin
      unique case (ins.op)
        OP_LDI: begin
          wr_en   = 1'b1;
          wr_data = DATA_W'(imm);
        end
        OP_ADD: begin
          wr_en   = 1'b1;
          wr_data = src_a + src_b;
        end
        OP_SUB: begin
          wr_en   = 1'b1;
          wr_data = src_a - src_b;
        end
        OP_STR: starts_store = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/tiny8_core.sv
module tiny8_core
  import tiny8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [PC_W-1:0]      imem_addr,
  input  logic [INSTR_W-1:0]   imem_rdata,
  output logic                 dmem_we,
  output logic [INSTR_W-1:0]   dmem_addr,
  output logic [DATA_W-1:0]    dmem_wdata,
  input  logic [REG_SEL_W-1:0] dbg_sel,
  output logic [DATA_W-1:0]    dbg_rdata,
  output logic [PC_W-1:0]      dbg_pc
);
  phase_e               phase_q;
  logic [REG_SEL_W-1:0] src_q;
  logic [PC_W-1:0]      pc;
  instr_t               ins;
  logic [REG_SEL_W-1:0] ra_sel;
  logic [DATA_W-1:0]    ra_data, rb_data;
  logic                 wr_en, starts_store;
  logic [REG_SEL_W-1:0] wr_sel;
  logic [DATA_W-1:0]    wr_data;

  assign ins    = instr_t'(imem_rdata);
  assign ra_sel = (phase_q == PH_ADDR) ? src_q : ins.rs1;

  tiny8_pc #(.PC_W(PC_W)) pc_i (
    .clk (clk),
    .rst (rst),
    .pc  (pc)
  );

  tiny8_regfile #(.DATA_W(DATA_W)) rf_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .ra_sel  (ra_sel),
    .rb_sel  (ins.rs2),
    .rc_sel  (dbg_sel),
    .ra_data (ra_data),
    .rb_data (rb_data),
    .rc_data (dbg_rdata)
  );

  tiny8_exec #(.DATA_W(DATA_W)) ex_i (
    .active       (phase_q == PH_EXEC),
    .ins          (ins),
    .src_a        (ra_data),
    .src_b        (rb_data),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .starts_store (starts_store)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_EXEC;
      src_q      <= '0;
      dmem_we    <= 1'b0;
      dmem_addr  <= '0;
      dmem_wdata <= '0;
    end else begin
      dmem_we <= 1'b0;
      if (phase_q == PH_ADDR) begin
        dmem_we    <= 1'b1;
        dmem_addr  <= imem_rdata;
        dmem_wdata <= ra_data;
        phase_q    <= PH_EXEC;
      end else if (starts_store) begin
        src_q   <= ins.rd;
        phase_q <= PH_ADDR;
      end
    end
  end

  assign imem_addr = pc;
  assign dbg_pc    = pc;
endmodule

// File: rtl/tiny8_core_chk.sv
module tiny8_core_chk #(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [7:0]      imem_rdata,
  input logic            dmem_we,
  input logic [7:0]      dmem_addr,
  input logic [PC_W-1:0] dbg_pc
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dbg_pc == '0 && !dmem_we));

  // R7
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> dbg_pc == PC_W'($past(dbg_pc) + 1'b1));

  // R5
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |=> !dmem_we);

  // R5
  we_addr_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> dmem_addr == $past(imem_rdata));

  // R8
  we_after_store_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> $past(imem_rdata, 2) >= 8'hC0);
endmodule

bind tiny8_core tiny8_core_chk #(.PC_W(PC_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .imem_rdata (imem_rdata),
  .dmem_we    (dmem_we),
  .dmem_addr  (dmem_addr),
  .dbg_pc     (dbg_pc)
);

// File: tb/tiny8_core_tb.sv
module tiny8_core_tb_top;
  localparam int NV = 12;
  // row: op[25:18] addr[17:10] sel[9:8] expected[7:0]
  localparam logic [25:0] VEC [NV] = '{
    {8'h15, 8'h00, 2'd1, 8'h05},  // R2 LOADI R1,5
    {8'h2F, 8'h00, 2'd2, 8'h0F},  // R2 LOADI R2,15
    {8'h76, 8'h00, 2'd3, 8'h14},  // R3 ADD R3=R1+R2
    {8'h86, 8'h00, 2'd0, 8'hF6},  // R4 SUB R0=R1-R2 borrow, R10
    {8'hBF, 8'h00, 2'd3, 8'h00},  // R4 SUB R3=R3-R3, R10
    {8'h6A, 8'h00, 2'd2, 8'h1E},  // R3 ADD R2=R2+R2, R10
    {8'h50, 8'h00, 2'd1, 8'hEC},  // R3 ADD R1=R0+R0 carry
    {8'hD0, 8'h3C, 2'd1, 8'hEC},  // R5 STORE R1 -> 3C
    {8'hCB, 8'hFF, 2'd0, 8'hF6},  // R6 STORE R0 junk low bits -> FF
    {8'h72, 8'h00, 2'd3, 8'h14},  // R3 ADD R3=R0+R2 carry
    {8'h00, 8'h00, 2'd0, 8'h00},  // R10 LOADI R0,0
    {8'hA1, 8'h00, 2'd2, 8'h14}   // R4 SUB R2=R0-R1
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dbg_rdata, dbg_pc;
  logic       dmem_we;
  logic [1:0] dbg_sel = 2'd0;
  logic [7:0] imem [256];
  int         checks = 0, errors = 0, cyc = 0;
  bit         done = 1'b0;
  logic [7:0] pc_exp = 8'd0;

  always #5 clk = ~clk;
  assign imem_rdata = imem[imem_addr];

  tiny8_core dut_i (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_we    (dmem_we),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dbg_sel    (dbg_sel),
    .dbg_rdata  (dbg_rdata),
    .dbg_pc     (dbg_pc)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_chk(input string req, input logic [1:0] sel, input logic [7:0] exp);
    dbg_sel = sel;
    #1;
    chk(req, dbg_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    int pa;
    for (int i = 0; i < 256; i++) imem[i] = 8'h00;
    pa = 0;
    for (int v = 0; v < NV; v++) begin
      imem[pa] = VEC[v][25:18];
      pa++;
      if (VEC[v][25:24] == 2'b11) begin
        imem[pa] = VEC[v][17:10];
        pa++;
      end
    end
    imem[pa] = 8'hC0;  // store opcode cut by reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pc", dbg_pc, 8'h00);
    chk("R1 we", {7'd0, dmem_we}, 8'h00);
    for (int r = 0; r < 4; r++) reg_chk("R1 reg", 2'(r), 8'h00);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      dbg_sel = VEC[v][9:8];
      @(posedge clk);
      @(negedge clk);
      pc_exp = pc_exp + 8'd1;
      chk("R7 pc", dbg_pc, pc_exp);
      chk("R9 imem_addr", imem_addr, pc_exp);
      if (VEC[v][25:24] == 2'b11) begin
        chk("R5 we low during address fetch", {7'd0, dmem_we}, 8'h00);
        @(posedge clk);
        @(negedge clk);
        pc_exp = pc_exp + 8'd1;
        chk("R7 pc after store", dbg_pc, pc_exp);
        chk("R5 we", {7'd0, dmem_we}, 8'h01);
        chk("R5 addr", dmem_addr, VEC[v][17:10]);
        chk("R5 data", dmem_wdata, VEC[v][7:0]);
        reg_chk("R6 source unchanged", VEC[v][9:8], VEC[v][7:0]);
      end else begin
        chk("R8 we low", {7'd0, dmem_we}, 8'h00);
        reg_chk("R2 R3 R4 R10 result", VEC[v][9:8], VEC[v][7:0]);
      end
    end
    // R6: full register state after both stores
    reg_chk("R6 final R0", 2'd0, 8'h00);
    reg_chk("R6 final R1", 2'd1, 8'hEC);
    reg_chk("R6 final R2", 2'd2, 8'h14);
    reg_chk("R6 final R3", 2'd3, 8'h14);

    // R1: reset while store address pending
    @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 no write on reset", {7'd0, dmem_we}, 8'h00);
    chk("R1 pc", dbg_pc, 8'h00);
    for (int r = 0; r < 4; r++) reg_chk("R1 reg cleared", 2'(r), 8'h00);

    // R7: store straddling the 255 -> 0 wrap
    for (int i = 0; i < 256; i++) imem[i] = 8'h3A;
    imem[0]   = 8'h42;
    imem[254] = 8'h29;
    imem[255] = 8'hE5;
    rst = 1'b0;
    repeat (255) @(posedge clk);
    @(negedge clk);
    chk("R7 pc at top", dbg_pc, 8'hFF);
    reg_chk("R2 R2 loaded", 2'd2, 8'h09);
    @(posedge clk);
    @(negedge clk);
    chk("R7 pc wrapped", dbg_pc, 8'h00);
    chk("R5 we low", {7'd0, dmem_we}, 8'h00);
    @(posedge clk);
    @(negedge clk);
    chk("R7 pc after wrap", dbg_pc, 8'h01);
    chk("R5 wrap we", {7'd0, dmem_we}, 8'h01);
    chk("R5 wrap addr", dmem_addr, 8'h42);
    chk("R5 wrap data", dmem_wdata, 8'h09);
    @(posedge clk);
    @(negedge clk);
    chk("R5 single pulse", {7'd0, dmem_we}, 8'h00);
    finish_run();
  end
endmodule